// File: doc/BRIEF.md
# Function-Unit Token Processor

This block is the control-side partner of a single function unit in a coarse-grained reconfigurable array. No operand select bits are held in configuration. Each operand multiplexer has a row of one-bit token lines, one per possible source. A token on a line announces that valid data will arrive on that source in the following cycle. The block turns the position of the arriving token into the multiplexer select. It raises a fetch strobe for the opcode and destination fields only when some token is present. One cycle later it issues the operation to the datapath.

On the issue cycle the fetched opcode is decoded into a latency and a token type, which is either data or predicate. A descriptor then waits in a latency-indexed shift register. When it leaves, a token is sent to the neighbours named by the two destination fields. Every token carries a staging-predicate bit, and the outgoing token carries the combined staging bit of the operands that fired the operation.

The issue controller is a two-state machine:
- **ISS_IDLE**: nothing issues in this cycle.
- **ISS_FIRE**: the operation captured in the previous cycle issues now.

Transitions:
- **ARM** (ISS_IDLE to ISS_FIRE): taken when any token arrives.
- **HOLD** (ISS_FIRE to ISS_FIRE): taken when tokens arrive again.
- **DRAIN** (ISS_FIRE to ISS_IDLE): taken when no token arrives.
- **REST** (ISS_IDLE to ISS_IDLE): taken when no token arrives.

Top module: `fu_token_engine`

## Requirements
- R1: While reset is held, `op_issue`, `op_opnd_vld`, `tok_out`, `tok_out_pred`, `tok_out_stg` and `conflict_err` are all zero.
- R2: `cfg_fetch_req` is high in exactly those cycles in which at least one bit of `tok_in` is high.
- R3: `op_issue` is high in cycle c+1 if and only if at least one token arrived in cycle c. This is exactly one stage between fetch and execute.
- R4: Operand k uses bits `tok_in[k*NUM_SRC +: NUM_SRC]`. In the issue cycle, its select field `op_sel[k*SEL_W +: SEL_W]` equals the index of the line that carried its token, and `op_opnd_vld[k]` is 1. An operand with no token shows select 0 and valid 0.
- R5: When two or more lines of one operand carry tokens in the same cycle, the lowest index is selected. `conflict_err` rises in the next cycle and stays high until reset.
- R6: On the issue cycle, `cfg_opc` is decoded as follows. Latency L equals `cfg_opc[1:0]` + 1, giving 1 to 4. Bit `cfg_opc[5]` set means a predicate token. The outgoing token appears exactly L cycles after the issue cycle, and `tok_out_pred` shows its type in that cycle.
- R7: The outgoing token sets `tok_out[n]` for each destination field (`cfg_dst0`, `cfg_dst1`) that equals n. A field value of `NUM_NBR` or more, including the null code 7, sends nothing. Two null fields send no token, and at most two bits of `tok_out` are ever high.
- R8: The staging bit of an operation is the AND of `tok_stg_in` at the selected line of every operand that had a token. It appears on `tok_out_stg` together with the outgoing token.
- R9: If a newer operation's token falls due in the same cycle as an older one's, the newer one replaces it.
- R10: Outside the issue cycle, `cfg_opc`, `cfg_dst0` and `cfg_dst1` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_in | input | NUM_OPND*NUM_SRC | Token lines, grouped by operand |
| tok_stg_in | input | NUM_OPND*NUM_SRC | Staging bit that goes with each token line |
| cfg_fetch_req | output | 1 | Request for the opcode and destination fields |
| cfg_opc | input | OPC_W | Fetched opcode field, valid in the issue cycle |
| cfg_dst0 | input | DEST_W | First destination neighbour index |
| cfg_dst1 | input | DEST_W | Second destination neighbour index |
| op_issue | output | 1 | The operation executes in this cycle |
| op_sel | output | NUM_OPND*SEL_W | Derived operand multiplexer selects |
| op_opnd_vld | output | NUM_OPND | Operand has a source in this issue |
| tok_out | output | NUM_NBR | Outgoing tokens, one per neighbour |
| tok_out_pred | output | 1 | The outgoing token is a predicate token |
| tok_out_stg | output | 1 | Staging bit of the outgoing token |
| conflict_err | output | 1 | Sticky flag for multiple tokens on one operand |

## Verification
A wrong state in the issue machine shows up one cycle after the token pattern that caused it. It appears as a missing or extra `op_issue`, or as a select that does not match the line that carried the token. A corrupted slot in the latency shift register only becomes visible when that slot reaches the head, up to four cycles after issue. It shows as a token sent to the wrong neighbour, sent in the wrong cycle, or carrying the wrong type or staging bit. Every cycle is therefore compared against a model, and token timing is checked at every latency, including an overlap where a newer token replaces an older one.

// File: rtl/fu_tok_pkg.sv
package fu_tok_pkg;

    // Issue controller states
    typedef enum logic [0:0] {
        ISS_IDLE = 1'b0,
        ISS_FIRE = 1'b1
    } iss_state_t;

endpackage

// File: rtl/fu_tok_rx.sv
module fu_tok_rx #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] lines,
    input  logic [NUM_SRC-1:0] stg,
    output logic               any_tok,
    output logic               multi_tok,
    output logic [SEL_W-1:0]   sel,
    output logic               win_stg
);

    // Walk from the top index down so the lowest index wins
    always_comb begin
        sel     = '0;
        win_stg = 1'b1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (lines[i]) begin
                sel     = SEL_W'(i);
                win_stg = stg[i];
            end
        end
        any_tok   = |lines;
        multi_tok = ($countones(lines) > 1);
    end

endmodule

// File: rtl/fu_tok_issue.sv
module fu_tok_issue
    import fu_tok_pkg::*;
#(
    parameter int NUM_OPND = 2,
    parameter int SEL_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_OPND-1:0]       any_tok,
    input  logic [NUM_OPND-1:0]       multi_tok,
    input  logic [NUM_OPND*SEL_W-1:0] sel_in,
    input  logic [NUM_OPND-1:0]       win_stg,
    output logic                      op_issue,
    output logic [NUM_OPND*SEL_W-1:0] op_sel,
    output logic [NUM_OPND-1:0]       op_opnd_vld,
    output logic                      op_stg,
    output logic                      conflict_err
);

    iss_state_t state_q, state_d;
    logic [NUM_OPND*SEL_W-1:0] sel_q;
    logic [NUM_OPND-1:0]       vld_q;
    logic                      stg_q;
    logic                      conf_q;
    logic                      stg_comb;
    logic                      tok_seen;

    assign tok_seen = |any_tok;

    always_comb begin
        stg_comb = 1'b1;
        for (int k = 0; k < NUM_OPND; k++) begin
            if (any_tok[k]) stg_comb = stg_comb & win_stg[k];
        end
    end

    // Next-state logic: ARM, HOLD, DRAIN and REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISS_IDLE: state_d = tok_seen ? ISS_FIRE : ISS_IDLE;
            ISS_FIRE: state_d = tok_seen ? ISS_FIRE : ISS_IDLE;
            default:  state_d = ISS_IDLE;
        endcase
    end

    // State and captured-operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
            sel_q   <= '0;
            vld_q   <= '0;
            stg_q   <= 1'b0;
            conf_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= tok_seen ? sel_in : '0;
            vld_q   <= any_tok;
            stg_q   <= tok_seen & stg_comb;
            conf_q  <= conf_q | (|multi_tok);
        end
    end

    // Outputs follow the state
    always_comb begin
        op_issue    = 1'b0;
        op_sel      = '0;
        op_opnd_vld = '0;
        op_stg      = 1'b0;
        unique case (state_q)
            ISS_IDLE: ;
            ISS_FIRE: begin
                op_issue    = 1'b1;
                op_sel      = sel_q;
                op_opnd_vld = vld_q;
                op_stg      = stg_q;
            end
            default: ;
        endcase
        conflict_err = conf_q;
    end

    // R5
    conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |=> conflict_err);

    // R4
    issue_has_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_issue |-> (op_opnd_vld != '0));

    // R5
    multi_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|multi_tok) |=> conflict_err);

endmodule

// File: rtl/fu_tok_emit.sv
module fu_tok_emit #(
    parameter int OPC_W   = 6,
    parameter int LAT_W   = 2,
    parameter int DEST_W  = 3,
    parameter int NUM_NBR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OPC_W-1:0]  opc,
    input  logic [DEST_W-1:0] dst0,
    input  logic [DEST_W-1:0] dst1,
    input  logic              stg,
    output logic [NUM_NBR-1:0] tok_out,
    output logic              tok_pred,
    output logic              tok_stg
);

    localparam int SLOTS    = 1 << LAT_W;
    localparam int PRED_BIT = OPC_W - 1;

    logic [SLOTS-1:0]              vld_q;
    logic [SLOTS-1:0]              pred_q;
    logic [SLOTS-1:0]              stg_q;
    logic [SLOTS-1:0][DEST_W-1:0]  d0_q;
    logic [SLOTS-1:0][DEST_W-1:0]  d1_q;
    logic [LAT_W-1:0]              slot_idx;

    // A latency of L lands in slot L-1, which is the raw opcode field
    assign slot_idx = opc[LAT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            pred_q <= '0;
            stg_q  <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (i == SLOTS - 1) begin
                    vld_q[i]  <= 1'b0;
                    pred_q[i] <= 1'b0;
                    stg_q[i]  <= 1'b0;
                    d0_q[i]   <= '0;
                    d1_q[i]   <= '0;
                end else begin
                    vld_q[i]  <= vld_q[i+1];
                    pred_q[i] <= pred_q[i+1];
                    stg_q[i]  <= stg_q[i+1];
                    d0_q[i]   <= d0_q[i+1];
                    d1_q[i]   <= d1_q[i+1];
                end
            end
            if (issue) begin
                vld_q[slot_idx]  <= 1'b1;
                pred_q[slot_idx] <= opc[PRED_BIT];
                stg_q[slot_idx]  <= stg;
                d0_q[slot_idx]   <= dst0;
                d1_q[slot_idx]   <= dst1;
            end
        end
    end

    // Fan-out to neighbours named in the destination fields
    for (genvar n = 0; n < NUM_NBR; n++) begin : g_fan
        assign tok_out[n] = vld_q[0] &&
                            ((d0_q[0] == DEST_W'(n)) || (d1_q[0] == DEST_W'(n)));
    end

    assign tok_pred = vld_q[0] & pred_q[0];
    assign tok_stg  = vld_q[0] & stg_q[0];

    // R7
    two_dest_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tok_out) <= 2);

    // R6
    unit_latency_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opc[LAT_W-1:0] == '0) |=> (tok_pred == $past(opc[PRED_BIT])));

endmodule

// File: rtl/fu_token_engine.sv
module fu_token_engine #(
    parameter int NUM_OPND = 2,
    parameter int NUM_SRC  = 4,
    parameter int OPC_W    = 6,
    parameter int LAT_W    = 2,
    parameter int DEST_W   = 3,
    parameter int NUM_NBR  = 4,
    parameter int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_OPND*NUM_SRC-1:0]  tok_in,
    input  logic [NUM_OPND*NUM_SRC-1:0]  tok_stg_in,
    output logic                         cfg_fetch_req,
    input  logic [OPC_W-1:0]             cfg_opc,
    input  logic [DEST_W-1:0]            cfg_dst0,
    input  logic [DEST_W-1:0]            cfg_dst1,
    output logic                         op_issue,
    output logic [NUM_OPND*SEL_W-1:0]    op_sel,
    output logic [NUM_OPND-1:0]          op_opnd_vld,
    output logic [NUM_NBR-1:0]           tok_out,
    output logic                         tok_out_pred,
    output logic                         tok_out_stg,
    output logic                         conflict_err
);

    logic [NUM_OPND-1:0]       any_tok;
    logic [NUM_OPND-1:0]       multi_tok;
    logic [NUM_OPND*SEL_W-1:0] rx_sel;
    logic [NUM_OPND-1:0]       rx_stg;
    logic                      op_stg;

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_rx
        fu_tok_rx #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W)
        ) u_rx (
            .lines     (tok_in[k*NUM_SRC +: NUM_SRC]),
            .stg       (tok_stg_in[k*NUM_SRC +: NUM_SRC]),
            .any_tok   (any_tok[k]),
            .multi_tok (multi_tok[k]),
            .sel       (rx_sel[k*SEL_W +: SEL_W]),
            .win_stg   (rx_stg[k])
        );
    end

    assign cfg_fetch_req = |any_tok;

    fu_tok_issue #(
        .NUM_OPND (NUM_OPND),
        .SEL_W    (SEL_W)
    ) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_tok      (any_tok),
        .multi_tok    (multi_tok),
        .sel_in       (rx_sel),
        .win_stg      (rx_stg),
        .op_issue     (op_issue),
        .op_sel       (op_sel),
        .op_opnd_vld  (op_opnd_vld),
        .op_stg       (op_stg),
        .conflict_err (conflict_err)
    );

    fu_tok_emit #(
        .OPC_W   (OPC_W),
        .LAT_W   (LAT_W),
        .DEST_W  (DEST_W),
        .NUM_NBR (NUM_NBR)
    ) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (op_issue),
        .opc      (cfg_opc),
        .dst0     (cfg_dst0),
        .dst1     (cfg_dst1),
        .stg      (op_stg),
        .tok_out  (tok_out),
        .tok_pred (tok_out_pred),
        .tok_stg  (tok_out_stg)
    );

    // R3
    fetch_then_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fetch_req |=> op_issue);

    // R3
    no_fetch_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fetch_req |=> !op_issue);

endmodule

// File: tb/fu_token_engine_bench.sv
module fu_token_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NO  = 2;
    localparam int NS  = 4;
    localparam int NN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tok_in = '0;
    logic [7:0] tok_stg_in = '0;
    logic [5:0] cfg_opc = '0;
    logic [2:0] cfg_dst0 = '0;
    logic [2:0] cfg_dst1 = '0;
    logic       cfg_fetch_req;
    logic       op_issue;
    logic [3:0] op_sel;
    logic [1:0] op_opnd_vld;
    logic [3:0] tok_out;
    logic       tok_out_pred;
    logic       tok_out_stg;
    logic       conflict_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    fu_token_engine u_fu_token_engine (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_stg_in(tok_stg_in),
        .cfg_fetch_req(cfg_fetch_req), .cfg_opc(cfg_opc), .cfg_dst0(cfg_dst0),
        .cfg_dst1(cfg_dst1), .op_issue(op_issue), .op_sel(op_sel),
        .op_opnd_vld(op_opnd_vld), .tok_out(tok_out), .tok_out_pred(tok_out_pred),
        .tok_out_stg(tok_out_stg), .conflict_err(conflict_err)
    );

    typedef struct {
        int         cyc;
        logic [3:0] sel;
        logic [1:0] vld;
        logic       stg;
    } iss_item_t;

    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    bit         run = 1'b0;
    bit         done = 1'b0;
    iss_item_t  iss_q[$];
    logic [6:0] exp_out [int];   // {vld, stg, pred, tok[3:0]}
    logic       exp_req = 1'b0;
    int         conf_at = 32'h7fffffff;
    logic       p_vld = 1'b0;
    logic [5:0] p_opc = '0;
    logic [2:0] p_d0 = '0;
    logic [2:0] p_d1 = '0;
    logic       p_stg = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Driver: tokens for this cycle; configuration for the op issuing now
    task automatic step(input logic [7:0] tok, input logic [7:0] stg,
                        input logic [5:0] opc, input logic [2:0] d0, input logic [2:0] d1);
        iss_item_t it;
        logic [3:0] fan;
        int lat;
        @(posedge clk); #1;
        tok_in     = tok;
        tok_stg_in = stg;
        if (p_vld) begin
            cfg_opc = p_opc; cfg_dst0 = p_d0; cfg_dst1 = p_d1;
            lat = int'(p_opc[1:0]) + 1;
            fan = '0;
            if (p_d0 < NN) fan[p_d0[1:0]] = 1'b1;
            if (p_d1 < NN) fan[p_d1[1:0]] = 1'b1;
            exp_out[cyc + lat] = {1'b1, p_stg, p_opc[5], fan};   // R9 newer overwrites
        end else begin
            // R10: junk configuration outside an issue cycle
            cfg_opc = $urandom; cfg_dst0 = $urandom; cfg_dst1 = $urandom;
        end
        exp_req = |tok;
        it.cyc = cyc + 1; it.sel = '0; it.vld = '0; it.stg = 1'b1;
        for (int k = 0; k < NO; k++) begin
            int hits = 0;
            for (int s = NS - 1; s >= 0; s--) begin
                if (tok[k*NS + s]) begin
                    it.sel[k*2 +: 2] = 2'(s);
                    it.vld[k] = 1'b1;
                    hits++;
                end
            end
            if (it.vld[k]) it.stg = it.stg & stg[k*NS + int'(it.sel[k*2 +: 2])];
            if (hits > 1 && conf_at > cyc + 1) conf_at = cyc + 1;
        end
        if (|tok) iss_q.push_back(it);
        p_vld = |tok; p_opc = opc; p_d0 = d0; p_d1 = d1; p_stg = it.stg;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (run) begin
            logic [6:0] e;
            check(cfg_fetch_req == exp_req, "R2 fetch", cfg_fetch_req, exp_req);
            if (op_issue) begin
                if (iss_q.size() == 0) begin
                    check(1'b0, "R3 unexpected issue", 1, 0);
                end else begin
                    iss_item_t it;
                    it = iss_q.pop_front();
                    check(it.cyc == cyc, "R3 issue timing", cyc, it.cyc);
                    check(op_sel == it.sel, "R4 R5 select", op_sel, it.sel);
                    check(op_opnd_vld == it.vld, "R4 operand valid", op_opnd_vld, it.vld);
                end
            end else if (iss_q.size() != 0 && iss_q[0].cyc <= cyc) begin
                check(1'b0, "R3 missing issue", 0, 1);
                void'(iss_q.pop_front());
            end
            e = exp_out.exists(cyc) ? exp_out[cyc] : 7'h0;
            check(tok_out == e[3:0], "R6 R7 R9 token out", tok_out, e[3:0]);
            check(tok_out_pred == (e[6] & e[4]), "R6 token type", tok_out_pred, e[6] & e[4]);
            check(tok_out_stg == (e[6] & e[5]), "R8 staging bit", tok_out_stg, e[6] & e[5]);
            check(conflict_err == (cyc >= conf_at), "R5 conflict flag", conflict_err, cyc >= conf_at);
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tok_in = 8'hff;
        #1;
        // R1: reset holds all outputs low even with tokens present
        check(op_issue == 0 && op_opnd_vld == 0, "R1 reset issue", {op_issue, op_opnd_vld}, 0);
        check(tok_out == 0 && tok_out_pred == 0 && tok_out_stg == 0, "R1 reset tokens", tok_out, 0);
        check(conflict_err == 0, "R1 reset conflict", conflict_err, 0);
        @(negedge clk);
        tok_in = '0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        run = 1'b1;
        // R4 single token, latency 1, one destination
        step(8'b0000_0100, 8'hff, 6'b000000, 3'd1, 3'd7);
        // R4 R6 R8 both operands, predicate, latency 4
        step(8'b0010_0001, 8'hff, 6'b100011, 3'd0, 3'd3);
        step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        // R7 both null; R8 zero staging bit
        step(8'b1000_0000, 8'b0111_1111, 6'b000001, 3'd7, 3'd7);
        // R7 out-of-range first field, latency 3
        step(8'b0000_0010, 8'hff, 6'b000010, 3'd5, 3'd2);
        step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        // R9 older latency 4 overtaken by newer latency 2
        step(8'b0001_0000, 8'hff, 6'b000011, 3'd0, 3'd7);
        step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        step(8'b0000_1000, 8'hff, 6'b100001, 3'd3, 3'd3);
        for (int i = 0; i < 6; i++) step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        // Back-to-back issue, R2 R3
        step(8'b0100_0000, 8'hff, 6'b000000, 3'd2, 3'd1);
        step(8'b0000_0001, 8'hff, 6'b000001, 3'd3, 3'd0);
        step(8'b0000_0000, 8'h00, 6'h00, 3'd0, 3'd0);
        // R5 two tokens on operand 0, lowest wins
        step(8'b0000_0110, 8'hff, 6'b000000, 3'd0, 3'd7);
        for (int i = 0; i < 400; i++) begin
            logic [7:0] t;
            t = 8'($urandom) & 8'($urandom) & 8'($urandom);
            step(t, 8'($urandom), 6'($urandom), 3'($urandom), 3'($urandom));
        end
        for (int i = 0; i < 8; i++) step(8'h00, 8'h00, 6'h00, 3'd0, 3'd0);
        @(negedge clk); #1;
        check(iss_q.size() == 0, "R3 pending issues", iss_q.size(), 0);
        run = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule